// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is a self-contained pulse-width-modulation output with its own two-stage clock prescaler and a 16-bit down-counting period counter, so it needs no shared timebase. Software programs a period value and a pulse-width value into holding registers through a small write/read port. The holding values are copied into the working registers only when the counter reloads at the end of a period, so a rewrite in mid-period never produces a shortened or stretched cycle on the pin.

Each counter tick moves the counter down by one. When the counter stands at one, it reloads from the period holding register and the width holding register is latched at the same time. The output is active while the counter is less than or equal to the working width. A polarity bit selects whether active means high or low. A sticky flag is raised at every reload and is cleared by a write.

The control sequencer has two states. `ST_IDLE` holds the counter and prescaler cleared and keeps the pin at its inactive level. `ST_RUN` counts and drives the pin. The transition START (`ST_IDLE` to `ST_RUN`, taken when `en` is high) loads the counter and both working registers from the holding registers. The transition STOP (`ST_RUN` to `ST_IDLE`, taken when `en` is low) clears the counter.

Top module: `dbuf_pwm`

## Requirements
- R1: After reset the period, width and control holding registers, the counter and the flag read 0, the state is `ST_IDLE`, and `pwm_out` is 0.
- R2: A write with `wr_en` high stores `wdata` at the rising edge. Address 0 holds the next period, address 1 the next width, and address 2 the control word: bits 7:0 prescale value `ps`, bit 8 polarity, bit 9 slow first stage. Bits above 9 read 0. Reads are combinational on `rdata`, and address 3 reads the live counter.
- R3: While running, the counter advances once every D clock cycles, with D = (slow ? 16 : 2) * (ps + 1). This gives a range of 2 to 4096. The first advance falls D cycles after START.
- R4: On a tick the counter decrements by one. If the counter is 1 (or 0) at that tick, it instead reloads from the next-period register, so a period value P gives P ticks per period.
- R5: While running, the output is active exactly when counter <= working width, and `pwm_out` = active XOR polarity (polarity 0 gives active-high, polarity 1 gives active-low).
- R6: Writes to the next-period and next-width registers reach the output only at the following reload. A write on the reload edge itself takes effect one period later.
- R7: A working width of 0 keeps the output inactive for the whole period. A working width greater than or equal to the working period keeps it active for the whole period.
- R8: The flag is set at every reload and cleared by a write to address 3. When both happen in the same cycle, the set wins.
- R9: In `ST_IDLE` the counter reads 0 and `pwm_out` equals the polarity bit. START loads the counter, working period and working width from the holding registers. STOP is taken on the first edge with `en` low.
- R10: A period value of 0 or 1 reloads at every tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel run enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for writes and reads |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data |
| pwm_out | output | 1 | Modulated output after polarity |
| flag | output | 1 | Sticky end-of-period flag |

## Verification
Two functions can fall in the same cycle: a reload and a software write. This covers a write of the next width or period landing on the reload edge, and a flag-clear write landing on the edge that sets the flag. The bench provokes both by using the shortest division and a short period, then writing a changing width or a flag clear on every cycle across several reloads, so some writes are certain to coincide with a reload. A behavioural model applies the rule that the reload takes the pre-write holding value and that set beats clear, and it is compared against `pwm_out` and `flag` on every clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_t;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_PER = 2'd0;
    localparam logic [ADDR_W-1:0] A_WID = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTL = 2'd2;
    localparam logic [ADDR_W-1:0] A_CNT = 2'd3;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  nxt_per,
    output logic [CNT_W-1:0]  nxt_wid,
    output logic [PRE_W+1:0]  ctl,
    output logic              flag_clr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_per <= '0;
            nxt_wid <= '0;
            ctl     <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_PER:   nxt_per <= wdata;
                A_WID:   nxt_wid <= wdata;
                A_CTL:   ctl     <= wdata[PRE_W+1:0];
                default: ;
            endcase
        end
    end

    assign flag_clr = wr_en && (addr == A_CNT);

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRE_W    = 8,
    parameter int SLOW_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] ps,
    input  logic             slow,
    output logic             tick
);

    localparam int S1_W = $clog2(SLOW_DIV);

    logic [S1_W-1:0]  s1_q;
    logic [S1_W-1:0]  s1_lim;
    logic [PRE_W-1:0] s2_q;
    logic             s1_done;
    logic             s2_done;

    assign s1_lim  = slow ? S1_W'(SLOW_DIV - 1) : S1_W'(1);
    assign s1_done = (s1_q == s1_lim);
    assign s2_done = (s2_q == ps);
    assign tick    = run && s1_done && s2_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else if (!run) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_done ? '0 : s1_q + 1'b1;
            if (s1_done) begin
                s2_q <= s2_done ? '0 : s2_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] nxt_per,
    input  logic [CNT_W-1:0] nxt_wid,
    output state_t           state,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_per,
    output logic [CNT_W-1:0] act_wid,
    output logic             reload,
    output logic             active,
    output logic             flag
);

    state_t state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (en)  state_d = ST_RUN;
            ST_RUN:  if (!en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    assign reload = (state == ST_RUN) && en && tick && (cnt <= CNT_W'(1));
    assign active = (state == ST_RUN) && (cnt <= act_wid);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            act_per <= '0;
            act_wid <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (en) begin
                        cnt     <= nxt_per;
                        act_per <= nxt_per;
                        act_wid <= nxt_wid;
                    end else begin
                        cnt <= '0;
                    end
                end
                ST_RUN: begin
                    if (!en) begin
                        cnt <= '0;
                    end else if (reload) begin
                        cnt     <= nxt_per;
                        act_per <= nxt_per;
                        act_wid <= nxt_wid;
                    end else if (tick) begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (reload)   flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

endmodule

// File: rtl/dbuf_pwm.sv
module dbuf_pwm
    import pwm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PRE_W    = 8,
    parameter int SLOW_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              pwm_out,
    output logic              flag
);

    localparam int CTL_W = PRE_W + 2;

    logic [CNT_W-1:0] nxt_per;
    logic [CNT_W-1:0] nxt_wid;
    logic [CTL_W-1:0] ctl;
    logic             flag_clr;
    logic             ctl_pol;
    logic             ctl_slow;
    logic [PRE_W-1:0] ctl_ps;
    logic             tick;
    state_t           st;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] act_per;
    logic [CNT_W-1:0] act_wid;
    logic             reload;
    logic             active;

    pwm_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .nxt_per  (nxt_per),
        .nxt_wid  (nxt_wid),
        .ctl      (ctl),
        .flag_clr (flag_clr)
    );

    assign ctl_ps   = ctl[PRE_W-1:0];
    assign ctl_pol  = ctl[PRE_W];
    assign ctl_slow = ctl[PRE_W+1];

    pwm_prescaler #(.PRE_W(PRE_W), .SLOW_DIV(SLOW_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st == ST_RUN),
        .ps    (ctl_ps),
        .slow  (ctl_slow),
        .tick  (tick)
    );

    pwm_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (tick),
        .flag_clr (flag_clr),
        .nxt_per  (nxt_per),
        .nxt_wid  (nxt_wid),
        .state    (st),
        .cnt      (cnt_q),
        .act_per  (act_per),
        .act_wid  (act_wid),
        .reload   (reload),
        .active   (active),
        .flag     (flag)
    );

    assign pwm_out = active ^ ctl_pol;

    always_comb begin
        unique case (addr)
            A_PER:   rdata = nxt_per;
            A_WID:   rdata = nxt_wid;
            A_CTL:   rdata = CNT_W'(ctl);
            default: rdata = cnt_q;
        endcase
    end

endmodule

// File: rtl/dbuf_pwm_checker.sv
module dbuf_pwm_checker
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             pwm_out,
    input logic             flag,
    input logic             pol,
    input state_t           st,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act_per,
    input logic [CNT_W-1:0] act_wid,
    input logic [CNT_W-1:0] nxt_per,
    input logic             tick,
    input logic             reload
);

    p_idle_inactive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (pwm_out == pol));

    p_start_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && en) |=> (cnt == $past(nxt_per)));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> (cnt <= act_per));

    p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && en && !tick) |=> $stable(cnt));

    p_flag_on_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> flag);

    p_zero_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && act_wid == '0) |-> (pwm_out == pol));

    p_full_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && act_wid >= act_per) |-> (pwm_out != pol));

endmodule

bind dbuf_pwm dbuf_pwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .pwm_out (pwm_out),
    .flag    (flag),
    .pol     (ctl_pol),
    .st      (st),
    .cnt     (cnt_q),
    .act_per (act_per),
    .act_wid (act_wid),
    .nxt_per (nxt_per),
    .tick    (tick),
    .reload  (reload)
);

// File: tb/dbuf_pwm_bench.sv
`timescale 1ns/1ps
module dbuf_pwm_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        pwm_out;
    logic        flag;

    always #5 clk = ~clk;

    dbuf_pwm u_dbuf_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pwm_out (pwm_out),
        .flag    (flag)
    );

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit m_on, m_pol, m_slow, m_flag, m_set, m_tk;
    int m_k, m_cnt, m_aw, m_np, m_nw, m_ps, m_div;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_on = 0; m_k = 0; m_cnt = 0; m_aw = 0; m_np = 0; m_nw = 0;
            m_ps = 0; m_slow = 0; m_pol = 0; m_flag = 0;
        end else begin
            m_set = 0;
            if (m_on) begin
                if (!en) begin
                    m_on = 0; m_cnt = 0;
                end else begin
                    m_div = (m_slow ? 16 : 2) * (m_ps + 1);
                    m_tk = ((m_k + 1) % m_div) == 0;
                    m_k++;
                    if (m_tk) begin
                        if (m_cnt <= 1) begin
                            m_cnt = m_np; m_aw = m_nw; m_set = 1;
                        end else begin
                            m_cnt--;
                        end
                    end
                end
            end else if (en) begin
                m_on = 1; m_k = 0; m_cnt = m_np; m_aw = m_nw;
            end
            if (wr_en) begin
                case (addr)
                    2'd0: m_np = wdata;
                    2'd1: m_nw = wdata;
                    2'd2: begin m_ps = wdata[7:0]; m_pol = wdata[8]; m_slow = wdata[9]; end
                    default: ;
                endcase
            end
            if (m_set) m_flag = 1;
            else if (wr_en && addr == 2'd3) m_flag = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_out;
            exp_out = m_on ? ((m_cnt <= m_aw) ^ m_pol) : m_pol;
            vectors++;
            if (pwm_out !== exp_out || flag !== m_flag) begin
                fails++;
                $display("FAIL %s cycle %0d pwm_out=%b flag=%b expected pwm_out=%b flag=%b",
                         cur_req, cycles, pwm_out, flag, exp_out, m_flag);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL %s watchdog cycles=%0d expected below 150000", cur_req, cycles);
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp_v, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        vectors++;
        if (rdata !== exp_v) begin
            fails++;
            $display("FAIL %s read addr %0d got %h expected %h", tag, a, rdata, exp_v);
        end
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        en = v;
    endtask

    initial begin
        // R1: reset state
        step(3);
        rst_n = 1'b1;
        rd_chk(2'd0, 16'h0000, "R1");
        rd_chk(2'd1, 16'h0000, "R1");
        rd_chk(2'd2, 16'h0000, "R1");
        rd_chk(2'd3, 16'h0000, "R1");

        // R2: register write and read back, unused control bits read 0
        cur_req = "R2";
        wr(2'd0, 16'd10);
        wr(2'd1, 16'd4);
        wr(2'd2, 16'hFC05);
        rd_chk(2'd0, 16'd10, "R2");
        rd_chk(2'd1, 16'd4, "R2");
        rd_chk(2'd2, 16'h0005, "R2");
        wr(2'd2, 16'h0000);

        // R4 and R5: active-high run, period 10 width 4
        cur_req = "R4";
        set_en(1'b1);
        rd_chk(2'd3, 16'd10, "R9");
        step(70);
        cur_req = "R5";
        set_en(1'b0);
        wr(2'd2, 16'h0100);
        set_en(1'b1);
        step(70);

        // R9: stop mid-period, idle level follows polarity, restart reloads
        cur_req = "R9";
        set_en(1'b0);
        step(10);
        rd_chk(2'd3, 16'd0, "R9");
        wr(2'd2, 16'h0000);
        step(5);
        wr(2'd0, 16'd6);
        set_en(1'b1);
        rd_chk(2'd3, 16'd6, "R9");
        step(40);

        // R6: rewrite width and period mid-period
        cur_req = "R6";
        wr(2'd1, 16'd2);
        step(3);
        wr(2'd0, 16'd3);
        step(40);

        // R7: zero width, width above period, width equal to period
        cur_req = "R7";
        wr(2'd1, 16'd0);
        step(30);
        wr(2'd1, 16'hFFFF);
        step(30);
        wr(2'd1, 16'd3);
        step(30);

        // R8 and R6 collision: per-cycle writes across reload edges
        cur_req = "R8";
        wr(2'd0, 16'd2);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            wr_en = 1'b1; addr = 2'd1; wdata = 16'(i % 3);
        end
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            wr_en = 1'b1; addr = 2'd3; wdata = 16'd0;
        end
        @(negedge clk);
        wr_en = 1'b0;
        step(10);

        // R10: period 0 and 1 reload every tick
        cur_req = "R10";
        wr(2'd1, 16'd1);
        wr(2'd0, 16'd0);
        step(20);
        wr(2'd0, 16'd1);
        step(20);

        // R3: division variants, restarted cleanly each time
        cur_req = "R3";
        set_en(1'b0);
        wr(2'd0, 16'd3);
        wr(2'd1, 16'd1);
        wr(2'd2, 16'h0202);
        set_en(1'b1);
        step(3 * 48 * 3);
        set_en(1'b0);
        wr(2'd2, 16'h0007);
        set_en(1'b1);
        step(3 * 16 * 3);
        set_en(1'b0);
        wr(2'd0, 16'd2);
        wr(2'd2, 16'h02FF);
        wr(2'd3, 16'd0);
        set_en(1'b1);
        step(2 * 4096 * 2 + 20);
        set_en(1'b0);
        step(5);

        finish_run();
    end

endmodule